// File: doc/BRIEF.md
# Cascaded Decimal Counter with Programmable Recycle

This block is a synchronous decimal counter that spans several digits. It is built from identical 4-bit BCD digit stages that all run on one clock. Each stage can advance, load in parallel or clear. A stage advances only when both enable inputs are high and every lower digit shows 9. The carry of one digit feeds the count enable of the next digit, so it never acts as a clock and every digit changes on the same edge.

A modulus decoder watches the whole count and makes the chain divide by a parameter `MODULUS`. When the chain is advancing and the count equals `MODULUS-1`, the decoder raises a synchronous clear, and the next edge returns every digit to zero instead of stepping to `MODULUS`. When `MODULUS` equals 10 to the power of the digit count, the natural wrap from all nines already gives the right period, so no decoded clear is wired. The design can load digit values above 9. The increment logic brings such a digit back to a legal value the next time it advances.

Top module: `decade_chain`

## Requirements
- R1: While reset is active, and after it is released with no other stimulus, `count` is zero and `digit_carry` is zero.
- R2: Digit 0 (bits 3:0 of `count`) steps by one on each clock edge where `en_p` and `en_t` are both high and neither `clr`, `load` nor `recycle` is active. From 9 it goes to 0.
- R3: Digit i (bits 4i+3:4i) for i above 0 steps only on an advancing edge where every lower digit equals 9. All digits share the same edge.
- R4: `digit_carry[i]` is high exactly when `en_t` is high and digits 0 through i all equal 9. It does not depend on `en_p`.
- R5: If `en_p` or `en_t` is low, and neither `clr` nor `load` is active, `count` does not change.
- R6: `clr` high clears every digit on the next edge. It overrides `load` and counting.
- R7: `load` high with `clr` low copies `load_val` into `count` on the next edge, whatever the enables are. It also overrides a recycle.
- R8: `recycle` is high exactly when `en_p` and `en_t` are high, `clr` and `load` are low, and every digit equals the matching BCD digit of `MODULUS-1`. The next edge then makes `count` zero, so an enabled chain runs through `MODULUS` states.
- R9: A digit that holds a value above 9 goes to 0 on its next advancing edge. It never raises a carry, because only the value 9 produces one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all digits |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous clear of all digits |
| load | input | 1 | Synchronous parallel load |
| en_p | input | 1 | Count enable that does not gate carries |
| en_t | input | 1 | Count enable that also gates carries |
| load_val | input | 4*DIGITS | BCD value to load, digit 0 in bits 3:0 |
| count | output | 4*DIGITS | Current count, digit 0 in bits 3:0 |
| digit_carry | output | DIGITS | Per-digit ripple-carry outputs |
| recycle | output | 1 | Modulus decode firing; the chain clears on the next edge |

## Verification
The bench first runs the chain freely from zero. This separates the low digit's 9-to-0 wrap from the tens digit's carry-driven step, and it ends on the decoded return from 78 to 0. Next it toggles each enable alone, which shows that `en_p` gates only counting while `en_t` also gates the carries. It then applies clear, load and recycle together to expose their priority order, and it loads digit values above 9 to show the recovery path and the missing carry. A long random run mixes all the controls against an integer digit model that is checked on every clock.

// File: rtl/decade_pkg.sv
package decade_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] bcd_t;
  localparam bcd_t BCD_TOP = 4'd9;

  // next value of a digit when it advances; any illegal value returns to zero
  function automatic bcd_t bcd_advance(bcd_t q);
    if (q >= BCD_TOP) return '0;
    return q + 4'd1;
  endfunction
endpackage

// File: rtl/decade_rst_sync.sv
module decade_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/decade_digit.sv
module decade_digit
  import decade_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  input  logic en_p,
  input  logic en_t,
  input  bcd_t ld_val,
  output bcd_t q,
  output logic rco
);
  bcd_t q_r;
  bcd_t q_nx;
  logic upd;

  always_comb begin
    upd  = clr | load | (en_p & en_t);
    q_nx = q_r;
    if (clr)                q_nx = '0;
    else if (load)          q_nx = ld_val;
    else if (en_p && en_t)  q_nx = bcd_advance(q_r);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_r <= '0;
    else if (upd) q_r <= q_nx;
  end

  assign q   = q_r;
  assign rco = en_t & (q_r == BCD_TOP);
endmodule

// File: rtl/decade_modulus_decode.sv
module decade_modulus_decode #(
  parameter int DIGITS  = 2,
  parameter int MODULUS = 79
) (
  input  logic [4*DIGITS-1:0] count,
  input  logic                en_p,
  input  logic                en_t,
  input  logic                clr,
  input  logic                load,
  output logic                recycle,
  output logic                clr_chain
);
  localparam int TARGET = MODULUS - 1;
  localparam int FULL   = 10 ** DIGITS;

  logic [DIGITS-1:0] hit;

  for (genvar gi = 0; gi < DIGITS; gi++) begin : g_hit
    localparam int DV = (TARGET / (10 ** gi)) % 10;
    assign hit[gi] = (count[4*gi +: 4] == 4'(DV));
  end

  assign recycle = en_p & en_t & ~clr & ~load & (&hit);

  if (MODULUS == FULL) begin : g_natural
    assign clr_chain = clr;
  end else begin : g_decode
    assign clr_chain = clr | recycle;
  end
endmodule

// File: rtl/decade_chain.sv
module decade_chain #(
  parameter int DIGITS  = 2,
  parameter int MODULUS = 79
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                load,
  input  logic                en_p,
  input  logic                en_t,
  input  logic [4*DIGITS-1:0] load_val,
  output logic [4*DIGITS-1:0] count,
  output logic [DIGITS-1:0]   digit_carry,
  output logic                recycle
);
  import decade_pkg::*;

  logic              rst_n_s;
  logic              clr_chain;
  logic [DIGITS-1:0] ent_chain;

  decade_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  decade_modulus_decode #(.DIGITS(DIGITS), .MODULUS(MODULUS)) u_dec (
    .count     (count),
    .en_p      (en_p),
    .en_t      (en_t),
    .clr       (clr),
    .load      (load),
    .recycle   (recycle),
    .clr_chain (clr_chain)
  );

  for (genvar gi = 0; gi < DIGITS; gi++) begin : g_digit
    if (gi == 0) begin : g_first
      assign ent_chain[gi] = en_t;
    end else begin : g_next
      assign ent_chain[gi] = digit_carry[gi-1];
    end

    decade_digit u_digit (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .clr    (clr_chain),
      .load   (load),
      .en_p   (en_p),
      .en_t   (ent_chain[gi]),
      .ld_val (load_val[4*gi +: 4]),
      .q      (count[4*gi +: 4]),
      .rco    (digit_carry[gi])
    );
  end
endmodule

// File: rtl/decade_chain_chk.sv
module decade_chain_chk #(
  parameter int DIGITS  = 2,
  parameter int MODULUS = 79
) (
  input logic                clk,
  input logic                rst_n,
  input logic                clr,
  input logic                load,
  input logic                en_p,
  input logic                en_t,
  input logic [4*DIGITS-1:0] load_val,
  input logic [4*DIGITS-1:0] count,
  input logic [DIGITS-1:0]   digit_carry,
  input logic                recycle
);
  localparam int CW = 4 * DIGITS;

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);

  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> count == $past(load_val));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load && !(en_p && en_t)) |=> $stable(count));

  p_carry_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_t |-> digit_carry == '0);

  p_recycle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    recycle |=> count == '0);

  p_illegal_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_p && en_t && !clr && !load && count[3:0] > 4'd9) |=> count[3:0] == 4'd0);

  p_low_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_p && en_t && !clr && !load && !recycle && count[3:0] < 4'd9)
      |=> count[3:0] == 4'($past(count[3:0]) + 4'd1));

  if (DIGITS > 1) begin : g_upper
    p_upper_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load && !recycle && count[3:0] != 4'd9)
        |=> count[CW-1:4] == $past(count[CW-1:4]));
  end
endmodule

bind decade_chain decade_chain_chk #(.DIGITS(DIGITS), .MODULUS(MODULUS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .clr         (clr),
  .load        (load),
  .en_p        (en_p),
  .en_t        (en_t),
  .load_val    (load_val),
  .count       (count),
  .digit_carry (digit_carry),
  .recycle     (recycle)
);

// File: tb/decade_chain_test.sv
module decade_chain_test;
  localparam int DIGITS  = 2;
  localparam int MODULUS = 79;
  localparam int CW      = 4 * DIGITS;

  logic          clk;
  logic          rst_n;
  logic          clr, load, en_p, en_t;
  logic [CW-1:0] load_val;
  logic [CW-1:0] count;
  logic [DIGITS-1:0] digit_carry;
  logic          recycle;

  decade_chain #(.DIGITS(DIGITS), .MODULUS(MODULUS)) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(load), .en_p(en_p), .en_t(en_t),
    .load_val(load_val), .count(count), .digit_carry(digit_carry), .recycle(recycle)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  int    md[DIGITS];
  string phase = "R1";
  bit    done  = 0;

  function automatic logic [CW-1:0] model_vec();
    logic [CW-1:0] v;
    for (int i = 0; i < DIGITS; i++) v[4*i +: 4] = 4'(md[i]);
    return v;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // apply one cycle of inputs, compare outputs, then advance the model
  task automatic step(bit c, bit l, bit p, bit t, logic [CW-1:0] v);
    logic [DIGITS-1:0] ec;
    bit run, hit, er, nr;
    @(negedge clk);
    clr = c; load = l; en_p = p; en_t = t; load_val = v;
    #1;
    chk(phase, "count", 32'(count), 32'(model_vec()));
    run = t;
    for (int i = 0; i < DIGITS; i++) begin
      run = run && (md[i] == 9);
      ec[i] = run;
    end
    chk("R4", "digit_carry", 32'(digit_carry), 32'(ec));
    hit = 1;
    for (int i = 0; i < DIGITS; i++)
      if (md[i] != ((MODULUS - 1) / (10 ** i)) % 10) hit = 0;
    er = p && t && !c && !l && hit;
    chk("R8", "recycle", 32'(recycle), 32'(er));
    if (c) begin
      for (int i = 0; i < DIGITS; i++) md[i] = 0;
    end else if (l) begin
      for (int i = 0; i < DIGITS; i++) md[i] = int'(v[4*i +: 4]);
    end else if (p && t) begin
      if (er) begin
        for (int i = 0; i < DIGITS; i++) md[i] = 0;
      end else begin
        run = 1;
        for (int i = 0; i < DIGITS; i++) begin
          if (run) begin
            nr = (md[i] == 9);
            md[i] = (md[i] >= 9) ? 0 : md[i] + 1;
            run = nr;
          end
        end
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DIGITS; i++) md[i] = 0;
    rst_n = 1'b0; clr = 0; load = 0; en_p = 0; en_t = 0; load_val = '0;
    repeat (3) @(negedge clk);
    chk("R1", "count in reset", 32'(count), 32'h0);
    chk("R1", "carry in reset", 32'(digit_carry), 32'h0);
    rst_n = 1'b1;
    phase = "R1";
    repeat (4) step(0, 0, 0, 0, '0);

    // R2: low digit counts 0..9
    phase = "R2";
    repeat (9) step(0, 0, 1, 1, '0);
    // R3: tens digit follows low digit carries up to 78
    phase = "R3";
    repeat (69) step(0, 0, 1, 1, '0);
    // R8: decoded recycle from 78 back to 0
    phase = "R8";
    repeat (5) step(0, 0, 1, 1, '0);

    // R5: either enable low holds the count
    phase = "R5";
    step(0, 1, 0, 0, 8'h49);
    step(0, 0, 0, 1, '0);
    step(0, 0, 1, 0, '0);
    step(0, 0, 0, 0, '0);
    step(0, 0, 0, 1, '0);
    step(0, 0, 1, 1, '0);
    step(0, 0, 1, 0, '0);

    // R6: clear beats load and count
    phase = "R6";
    step(1, 1, 1, 1, 8'h55);
    step(1, 0, 0, 0, '0);
    step(0, 0, 0, 0, '0);

    // R7: load regardless of enables, and over recycle
    phase = "R7";
    step(0, 1, 0, 0, 8'h57);
    step(0, 0, 1, 1, '0);
    step(0, 1, 1, 1, 8'h78);
    step(0, 1, 1, 1, 8'h12);
    step(0, 0, 0, 0, '0);

    // R9: illegal digit values recover without carry
    phase = "R9";
    step(0, 1, 0, 0, 8'h0C);
    step(0, 0, 1, 1, '0);
    step(0, 0, 1, 1, '0);
    step(0, 1, 0, 0, 8'hA9);
    step(0, 0, 1, 1, '0);
    step(0, 1, 0, 0, 8'hF9);
    step(0, 0, 1, 1, '0);
    step(0, 0, 1, 1, '0);

    // random mix, every output compared each clock
    phase = "R4";
    for (int k = 0; k < 400; k++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 3, (r >= 3) && (r < 9), $urandom_range(0, 7) != 0,
           $urandom_range(0, 7) != 0, CW'($urandom));
    end
    step(0, 0, 0, 0, '0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule